// File: doc/BRIEF.md
# Dot-Matrix Common/Segment Scan Engine

This block produces the multiplexed refresh of a character display organised as 16 common rows by 40 segment columns, driven at 1/16 duty. The panel shows 16 character cells of 5 dots by 8 dot rows: the upper eight commons carry the eight dot rows of cells 0 to 7, and the lower eight carry those of cells 8 to 15. For the row it is preparing, the engine walks the eight cells of that half. For each cell it reads a character code from an external display memory and turns it into a 5-dot row pattern. Codes with a zero upper nibble take that pattern from a small user pattern memory; all other codes take it from a built-in stub pattern generator.

The 40 resulting dots are shifted one per clock into a segment shift register. At the end of the line period they move into an output latch, and that common becomes active. A cursor underline, a blinking all-on cell, a display blanking control, a circular display shift and an output rotation mode are applied along the way. The memories sit outside the block and answer reads within the same cycle. The configuration inputs are expected to stay static across a frame.

Top module: `dmx_scan_engine`

## Requirements
- R1: After reset, com_o and seg_o stay all zero until the first line period of LINE_CLKS clocks ends; at that boundary the common for row 0 becomes active.
- R2: At most one bit of com_o is high. Rows are shown in the order 0,1,...,15 and then wrap. Each row stays active for exactly LINE_CLKS clocks, so a frame lasts 16*LINE_CLKS clocks.
- R3: Row r shows dot row r mod 8 of display positions 0-7 (r<8) or 8-15 (r>=8). With addr_mode_i=0, position q reads address q. With addr_mode_i=1, positions 0-7 read 00h-07h and positions 8-15 read 40h-47h.
- R4: Within a row, seg_o index 5*c+d holds dot d of position slot c, where dot 0 is the leftmost dot and equals bit 4 of the 5-bit row pattern. The latched value is held for the whole period in which that common is active.
- R5: A code whose bits 7:4 are 0000 reads the user pattern memory at address {code[1:0], dotrow[2:0]} and uses data bits 4:0. Code bits 3:2 have no effect.
- R6: Any other code yields the stub pattern code[4:0] XOR {dotrow[2:0], dotrow[1:0]}.
- R7: With cur_on_i=1, dot row 7 of the cell whose address equals cur_addr_i shows all five dots on. Pattern dots set in row 7 show whether or not the cursor is on.
- R8: With blink_on_i=1, the cell at cur_addr_i shows all dots on during the on phase and the normal pattern during the off phase. The phase flips every BLINK_FRAMES frames and is off after reset.
- R9: With disp_on_i=0, every segment is blank while the commons keep scanning.
- R10: With shift value k (shift_i), display position p shows entry (p+k) mod 16 of the mode's 16-address sequence (k=1 shows 01h..0Fh,00h in mode 0; k=15 shows 0Fh,00h..0Eh).
- R11: With rotate_i=1, seg_o[39-i] carries what seg_o[i] would carry and com_o[15-r] carries what com_o[r] would carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| disp_on_i | input | 1 | 1 shows data, 0 blanks all segments |
| cur_on_i | input | 1 | Cursor underline enable |
| blink_on_i | input | 1 | Blinking cursor cell enable |
| addr_mode_i | input | 1 | 0: addresses 00h-0Fh, 1: 00h-07h and 40h-47h |
| rotate_i | input | 1 | Reverse segment and common order |
| shift_i | input | 4 | Circular display shift count (left) |
| cur_addr_i | input | 7 | Display address of the cursor cell |
| dd_addr_o | output | 7 | Display memory read address |
| dd_data_i | input | 8 | Character code at dd_addr_o, same cycle |
| ug_addr_o | output | 5 | User pattern memory read address |
| ug_data_i | input | 5 | User pattern row at ug_addr_o, same cycle |
| com_o | output | 16 | Common select, one-hot or zero |
| seg_o | output | 40 | Latched segment data |

## Verification
The bench builds the engine with LINE_CLKS=48 and BLINK_FRAMES=2, so a frame lasts 768 clocks and a blink half-period lasts two frames. Many configurations can then be settled for two frames each and compared on every row. The full blink cycle can be watched over eight frames, checking that the cursor cell changes state every second frame. The short line period also keeps the idle tail after the 40 shift clocks small while still leaving it present, and the reset-to-first-common latency stays easy to count.

// File: rtl/dmx_scan_pkg.sv
package dmx_scan_pkg;
    localparam int NCOM     = 16;
    localparam int CHARS    = 8;
    localparam int DOTS     = 5;
    localparam int SEGS     = CHARS * DOTS;
    localparam int ROW_W    = $clog2(NCOM);
    localparam int SLOT_W   = $clog2(CHARS);
    localparam int DOT_W    = $clog2(DOTS);

    typedef logic [ROW_W-1:0]  row_t;
    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [DOT_W-1:0]  dot_t;
    typedef logic [DOTS-1:0]   pat_t;
    typedef logic [6:0]        dd_addr_t;
endpackage

// File: rtl/dmx_scan_timer.sv
module dmx_scan_timer
    import dmx_scan_pkg::*;
#(
    parameter int LINE_CLKS    = 160,
    parameter int BLINK_FRAMES = 32
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    output logic  shift_en_o,
    output logic  line_end_o,
    output row_t  row_o,
    output slot_t slot_o,
    output dot_t  dot_o,
    output logic  blink_ph_o
);
    localparam int LCW = $clog2(LINE_CLKS);
    localparam int FCW = $clog2(BLINK_FRAMES + 1);

    typedef struct packed {
        logic [LCW-1:0] lc;
        row_t           row;
        slot_t          slot;
        dot_t           dot;
        logic [FCW-1:0] fcnt;
        logic           ph;
    } tstate_t;

    tstate_t q, d;

    always_comb begin
        d          = q;
        shift_en_o = (q.lc < LCW'(SEGS));
        line_end_o = (q.lc == LCW'(LINE_CLKS - 1));
        if (line_end_o) begin
            d.lc   = '0;
            d.slot = '0;
            d.dot  = '0;
            d.row  = q.row + 1'b1;
            if (q.row == row_t'(NCOM - 1)) begin
                if (q.fcnt == FCW'(BLINK_FRAMES - 1)) begin
                    d.fcnt = '0;
                    d.ph   = ~q.ph;
                end else begin
                    d.fcnt = q.fcnt + 1'b1;
                end
            end
        end else begin
            d.lc = q.lc + 1'b1;
            if (shift_en_o) begin
                if (q.dot == dot_t'(DOTS - 1)) begin
                    d.dot  = '0;
                    d.slot = q.slot + 1'b1;
                end else begin
                    d.dot = q.dot + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign row_o      = q.row;
    assign slot_o     = q.slot;
    assign dot_o      = q.dot;
    assign blink_ph_o = q.ph;

    // R8
    blink_frame_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(line_end_o && (q.row == row_t'(NCOM - 1))) |-> $stable(q.ph));
endmodule

// File: rtl/dmx_scan_fetch.sv
module dmx_scan_fetch
    import dmx_scan_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  row_t     row_i,
    input  slot_t    slot_i,
    input  dot_t     dot_i,
    input  logic     blink_ph_i,
    input  logic     disp_on_i,
    input  logic     cur_on_i,
    input  logic     blink_on_i,
    input  logic     addr_mode_i,
    input  logic [3:0] shift_i,
    input  dd_addr_t cur_addr_i,
    output dd_addr_t dd_addr_o,
    input  logic [7:0] dd_data_i,
    output logic [4:0] ug_addr_o,
    input  pat_t     ug_data_i,
    output logic     bit_o
);
    logic [2:0] drow;
    logic [3:0] pos, q;
    logic       user_code, cur_cell;
    pat_t       pat;
    logic       unused_code_bits;

    assign unused_code_bits = ^dd_data_i[3:2];

    always_comb begin
        drow      = row_i[2:0];
        pos       = {row_i[3], slot_i};
        q         = pos + shift_i;
        dd_addr_o = addr_mode_i ? {q[3], 3'b000, q[2:0]} : {3'b000, q};
        user_code = (dd_data_i[7:4] == 4'h0);
        ug_addr_o = {dd_data_i[1:0], drow};
        pat       = user_code ? ug_data_i
                              : (dd_data_i[4:0] ^ {drow, drow[1:0]});
        cur_cell  = (dd_addr_o == cur_addr_i);
        if (cur_on_i && cur_cell && (drow == 3'd7)) pat = '1;
        if (blink_on_i && blink_ph_i && cur_cell)   pat = '1;
        if (!disp_on_i)                             pat = '0;
        bit_o = pat[3'(DOTS - 1) - 3'(dot_i)];
    end

    // R3
    addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        addr_mode_i ? (dd_addr_o[5:3] == 3'b000) : (dd_addr_o[6:4] == 3'b000));
endmodule

// File: rtl/dmx_scan_seglatch.sv
module dmx_scan_seglatch
    import dmx_scan_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            shift_en_i,
    input  logic            line_end_i,
    input  row_t            row_i,
    input  logic            bit_i,
    input  logic            rotate_i,
    output logic [NCOM-1:0] com_o,
    output logic [SEGS-1:0] seg_o
);
    typedef struct packed {
        logic [SEGS-1:0] sr;
        logic [SEGS-1:0] lat;
        row_t            act;
        logic            live;
    } lstate_t;

    lstate_t q, d;

    always_comb begin
        d = q;
        if (shift_en_i) d.sr = {bit_i, q.sr[SEGS-1:1]};
        if (line_end_i) begin
            d.lat  = q.sr;
            d.act  = row_i;
            d.live = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    for (genvar i = 0; i < SEGS; i++) begin : g_seg
        assign seg_o[i] = rotate_i ? q.lat[SEGS-1-i] : q.lat[i];
    end
    for (genvar j = 0; j < NCOM; j++) begin : g_com
        assign com_o[j] = q.live &&
            (q.act == (rotate_i ? row_t'(NCOM - 1 - j) : row_t'(j)));
    end

    // R2
    com_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(com_o));
    // R2
    com_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$past(line_end_i) && $stable(rotate_i)) |-> $stable(com_o));
    // R1
    idle_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (com_o == '0) |-> (seg_o == '0));
endmodule

// File: rtl/dmx_scan_engine.sv
module dmx_scan_engine
    import dmx_scan_pkg::*;
#(
    parameter int LINE_CLKS    = 160,
    parameter int BLINK_FRAMES = 32
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        disp_on_i,
    input  logic        cur_on_i,
    input  logic        blink_on_i,
    input  logic        addr_mode_i,
    input  logic        rotate_i,
    input  logic [3:0]  shift_i,
    input  logic [6:0]  cur_addr_i,
    output logic [6:0]  dd_addr_o,
    input  logic [7:0]  dd_data_i,
    output logic [4:0]  ug_addr_o,
    input  logic [4:0]  ug_data_i,
    output logic [15:0] com_o,
    output logic [39:0] seg_o
);
    logic  shift_en, line_end, blink_ph, dot_bit;
    row_t  row;
    slot_t slot;
    dot_t  dot;

    dmx_scan_timer #(.LINE_CLKS(LINE_CLKS), .BLINK_FRAMES(BLINK_FRAMES)) timer_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .shift_en_o(shift_en), .line_end_o(line_end),
        .row_o(row), .slot_o(slot), .dot_o(dot), .blink_ph_o(blink_ph));

    dmx_scan_fetch fetch_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .row_i(row), .slot_i(slot), .dot_i(dot),
        .blink_ph_i(blink_ph), .disp_on_i(disp_on_i), .cur_on_i(cur_on_i),
        .blink_on_i(blink_on_i), .addr_mode_i(addr_mode_i), .shift_i(shift_i),
        .cur_addr_i(cur_addr_i), .dd_addr_o(dd_addr_o), .dd_data_i(dd_data_i),
        .ug_addr_o(ug_addr_o), .ug_data_i(ug_data_i), .bit_o(dot_bit));

    dmx_scan_seglatch latch_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .shift_en_i(shift_en), .line_end_i(line_end),
        .row_i(row), .bit_i(dot_bit), .rotate_i(rotate_i), .com_o(com_o), .seg_o(seg_o));
endmodule

// File: tb/dmx_scan_engine_tb_top.sv
module dmx_scan_engine_tb_top;
    localparam int LC    = 48;
    localparam int BF    = 2;
    localparam int FRAME = 16 * LC;

    typedef struct packed {
        logic       d, c, m, rt;
        logic [3:0] sh;
        logic [6:0] ca;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  7'h7F},
        '{1'b1, 1'b1, 1'b0, 1'b0, 4'd0,  7'h03},
        '{1'b1, 1'b0, 1'b1, 1'b0, 4'd0,  7'h7F},
        '{1'b1, 1'b1, 1'b1, 1'b0, 4'd1,  7'h41},
        '{1'b1, 1'b0, 1'b0, 1'b1, 4'd5,  7'h7F},
        '{1'b0, 1'b1, 1'b0, 1'b0, 4'd0,  7'h00},
        '{1'b1, 1'b0, 1'b0, 1'b0, 4'd15, 7'h7F}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        disp_on, cur_on, blink_on, addr_mode, rotate;
    logic [3:0]  shift;
    logic [6:0]  cur_addr, dd_addr;
    logic [7:0]  dd_data;
    logic [4:0]  ug_addr, ug_data;
    logic [15:0] com;
    logic [39:0] seg;
    logic [7:0]  ddr [128];
    logic [4:0]  ug  [32];
    int checks = 0, fails = 0, cyc = 0;

    assign dd_data = ddr[dd_addr];
    assign ug_data = ug[ug_addr];
    always @(posedge clk) cyc <= cyc + 1;

    dmx_scan_engine #(.LINE_CLKS(LC), .BLINK_FRAMES(BF)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .disp_on_i(disp_on), .cur_on_i(cur_on),
        .blink_on_i(blink_on), .addr_mode_i(addr_mode), .rotate_i(rotate),
        .shift_i(shift), .cur_addr_i(cur_addr), .dd_addr_o(dd_addr),
        .dd_data_i(dd_data), .ug_addr_o(ug_addr), .ug_data_i(ug_data),
        .com_o(com), .seg_o(seg));

    task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [39:0] model(input int r, input vec_t v);
        logic [39:0] nv, e;
        for (int s = 0; s < 8; s++) begin
            int p = ((r >= 8) ? 8 : 0) + s;
            int qq = (p + int'(v.sh)) % 16;
            logic [6:0] a = v.m ? ((qq < 8) ? 7'(qq) : 7'(64 + qq - 8)) : 7'(qq);
            logic [7:0] code = ddr[a];
            logic [2:0] dr = 3'(r % 8);
            logic [4:0] pat = (code[7:4] == 4'h0) ? ug[{code[1:0], dr}]
                                                  : (code[4:0] ^ {dr, dr[1:0]});
            if (v.c && a == v.ca && dr == 3'd7) pat = 5'h1F;
            if (!v.d) pat = 5'h00;
            for (int k = 0; k < 5; k++) nv[s*5+k] = pat[4-k];
        end
        for (int i = 0; i < 40; i++) e[i] = v.rt ? nv[39-i] : nv[i];
        return e;
    endfunction

    function automatic string tag_of(input int i);
        case (i)
            0: return "R3 R4 R5 R6";
            1: return "R7";
            2: return "R3 mode1";
            3: return "R10 R7";
            4: return "R11 R10";
            5: return "R9";
            default: return "R10 right";
        endcase
    endfunction

    task automatic apply(input vec_t v, input logic bl);
        @(negedge clk);
        disp_on = v.d; cur_on = v.c; addr_mode = v.m; rotate = v.rt;
        shift = v.sh; cur_addr = v.ca; blink_on = bl;
    endtask

    task automatic check_row(input int r, input vec_t v, input string tag);
        int idx = v.rt ? 15 - r : r;
        logic [15:0] oh = 16'h1 << idx;
        wait (com == oh);
        @(negedge clk);
        chk(seg == model(r, v), $sformatf("%s row %0d", tag, r), seg, model(r, v));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        bit s [8];
        int n, t0;
        for (int a = 0; a < 128; a++) ddr[a] = 8'((a * 37 + 11) & 8'hFF);
        ddr[7'h03] = 8'h0E;
        ddr[7'h42] = 8'h05;
        ddr[7'h09] = 8'h07;
        ddr[7'h41] = 8'h02;
        for (int i = 0; i < 32; i++) ug[i] = 5'((i * 7 + 3) & 5'h1F);
        disp_on = 1; cur_on = 0; blink_on = 0; addr_mode = 0; rotate = 0;
        shift = 0; cur_addr = 7'h7F;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        chk(com == 0 && seg == 0, "R1 reset state", {com, seg[23:0]}, 40'h0);
        repeat (LC - 1) @(posedge clk);
        @(negedge clk);
        chk(com == 0, "R1 before first boundary", {24'h0, com}, 40'h0);
        @(posedge clk); @(negedge clk);
        chk(com == 16'h1, "R1 first common", {24'h0, com}, 40'h1);
        chk(seg == model(0, VECS[0]), "R4 first row data", seg, model(0, VECS[0]));

        // R2 line length
        wait (com == 16'h2);
        @(negedge clk);
        n = 0;
        while (com == 16'h2) begin @(negedge clk); n++; end
        chk(n == LC, "R2 line period", 40'(n), 40'(LC));
        // R2 frame length
        wait (com == 16'h1); t0 = cyc;
        wait (com != 16'h1); wait (com == 16'h1);
        chk(cyc - t0 == FRAME, "R2 frame period", 40'(cyc - t0), 40'(FRAME));

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i], 1'b0);
            repeat (2 * FRAME) @(posedge clk);
            for (int r = 0; r < 16; r++) check_row(r, VECS[i], tag_of(i));
        end

        // R8 blink cell at address 00h, row 0, slot 0
        apply('{1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 7'h00}, 1'b1);
        repeat (2 * FRAME) @(posedge clk);
        for (int i = 0; i < 8; i++) begin
            wait (com != 16'h1); wait (com == 16'h1);
            @(negedge clk);
            s[i] = (seg[4:0] == 5'h1F);
        end
        for (int i = 0; i < 6; i++)
            chk(s[i] != s[i+2], $sformatf("R8 blink frame %0d", i), 40'(s[i]), 40'(!s[i+2]));
        chk(s[0] != s[1] || s[1] != s[2], "R8 blink both phases", 40'(s[0]), 40'(s[2]));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule